// File: doc/BRIEF.md
# Timer Compare Output Waveform Generator

This block turns the running value of an 8-bit timer/counter into the level of one output-compare pin. On every counter-advance strobe it compares the count against a compare value and a TOP value. From those two events, the waveform family, a 2-bit output mode, an extra mode bit and the count direction, it decides whether to hold, clear, set or toggle an internal waveform register.

Three families are supported. In the plain family the pin reacts only to a compare match. The single-slope fast PWM family adds an action at TOP. The dual-slope phase-correct family makes the match action depend on whether the counter is rising or falling. The block also reports whether the timer has taken over the pin, so that a port multiplexer can route the waveform out. A pin-direction enable must be set before the pin is actually driven.

Top module: `ocg_wavegen`

## Requirements
- R1: While `rst` is high at a clock edge, the waveform register, `pin_out` and `pin_own` are all forced to 0 after that edge, whatever the other inputs are.
- R2: `wave_fam` encodes the family: 0 and 3 are plain (non-PWM), 1 is fast PWM, 2 is phase-correct PWM. In the plain family, a match (strobe with `cnt_val == cmp_val`) toggles the waveform for `out_mode` 1, clears it for 2 and sets it for 3.
- R3: In fast PWM with `cmp_val != top_val`, `out_mode` 2 clears on a match and sets when `cnt_val == top_val`. `out_mode` 3 sets on a match and clears at TOP. An action at TOP wins over a match on the same count.
- R4: In phase-correct PWM with `cmp_val != top_val`, `out_mode` 2 clears on a match while `cnt_down` is 0 and sets on a match while `cnt_down` is 1. `out_mode` 3 does the reverse.
- R5: In either PWM family, `out_mode` 1 with `ext_mode` 0 leaves the pin disconnected: `pin_own` is 0 and the waveform does not change. With `ext_mode` 1 it toggles on each match.
- R6: In either PWM family, if `cmp_val == top_val` and `out_mode` is 2 or 3, a match is ignored. At TOP the waveform is set (mode 2) or cleared (mode 3).
- R7: Matches and TOP events count only on cycles with `cnt_step` high. With `cnt_step` low the waveform is unchanged, even if the count equals the compare value.
- R8: After each edge, `pin_own` is 1 exactly when the sampled mode is connected (nonzero and not the R5 disconnected case) and `dir_en` was 1. `pin_out` equals the new waveform value when `pin_own` is 1, and is 0 otherwise.
- R9: While the pin is disconnected, the waveform register keeps its value. When a mode reconnects it, that retained level reappears on `pin_out` without any new event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_step | input | 1 | Counter-advance strobe; events are evaluated only when high |
| cnt_val | input | W | Current counter value |
| cnt_down | input | 1 | 1 while the counter is falling (phase-correct family) |
| cmp_val | input | W | Compare value |
| top_val | input | W | TOP value of the count cycle |
| out_mode | input | 2 | Output mode: 0 off, 1 toggle, 2 clear-type, 3 set-type |
| wave_fam | input | 2 | Waveform family: 0/3 plain, 1 fast PWM, 2 phase-correct PWM |
| ext_mode | input | 1 | Extra mode bit enabling toggle in the PWM families |
| dir_en | input | 1 | Pin direction enable; the pin is driven only when set |
| pin_out | output | 1 | Registered pin level |
| pin_own | output | 1 | Registered flag: timer drives the pin |

## Verification
The compare match and the TOP event can fall on the same counter step, and this happens only when the compare value equals TOP. The sweep provokes it by running every family and mode with a compare value of TOP, as well as with 0 and with a mid value. At that count the expected level comes from the TOP action alone, and the pin must show the set or clear of R6 and never the match action. A second collision, a stalled cycle whose count equals the compare value, follows every step and must leave the pin unchanged.

// File: rtl/ocg_pkg.sv
package ocg_pkg;

  typedef enum logic [1:0] {
    FAM_PLAIN = 2'd0,
    FAM_FAST  = 2'd1,
    FAM_DUAL  = 2'd2,
    FAM_RSVD  = 2'd3
  } fam_e;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_CLR  = 2'd1,
    ACT_SET  = 2'd2,
    ACT_TOG  = 2'd3
  } act_e;

  typedef struct packed {
    logic hit;         // strobe and count equals compare
    logic at_top;      // strobe and count equals TOP
    logic cmp_is_top;  // compare value sits on TOP
  } evt_t;

endpackage

// File: rtl/ocg_event.sv
module ocg_event
  import ocg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         cnt_step,
  input  logic [W-1:0] cnt_val,
  input  logic [W-1:0] cmp_val,
  input  logic [W-1:0] top_val,
  output evt_t         evt
);

  always_comb begin
    evt.cmp_is_top = (cmp_val == top_val);
    evt.hit        = cnt_step && (cnt_val == cmp_val);
    evt.at_top     = cnt_step && (cnt_val == top_val);
  end

endmodule

// File: rtl/ocg_decode.sv
module ocg_decode
  import ocg_pkg::*;
(
  input  logic [1:0] wave_fam,
  input  logic [1:0] out_mode,
  input  logic       ext_mode,
  input  logic       cnt_down,
  input  evt_t       evt,
  output act_e       act,
  output logic       linked
);

  fam_e fam;
  logic pwm;
  act_e top_act;
  act_e hit_act;

  always_comb begin
    fam    = fam_e'(wave_fam);
    pwm    = (fam == FAM_FAST) || (fam == FAM_DUAL);
    linked = (out_mode != 2'b00) && !(pwm && out_mode == 2'b01 && !ext_mode);

    // TOP action for the clear/set modes: mode 2 sets, mode 3 clears
    top_act = out_mode[0] ? ACT_CLR : ACT_SET;
    // match action on a rising count: mode 2 clears, mode 3 sets
    hit_act = out_mode[0] ? ACT_SET : ACT_CLR;

    act = ACT_HOLD;
    if (linked) begin
      if (!pwm) begin
        if (evt.hit) act = (out_mode == 2'b01) ? ACT_TOG : hit_act;
      end else if (out_mode == 2'b01) begin
        if (evt.hit) act = ACT_TOG;
      end else if (evt.cmp_is_top) begin
        if (evt.at_top) act = top_act;
      end else if (fam == FAM_FAST) begin
        if (evt.at_top)   act = top_act;
        else if (evt.hit) act = hit_act;
      end else begin
        if (evt.hit) act = cnt_down ? top_act : hit_act;
      end
    end
  end

endmodule

// File: rtl/ocg_wavegen.sv
module ocg_wavegen
  import ocg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_step,
  input  logic [W-1:0] cnt_val,
  input  logic         cnt_down,
  input  logic [W-1:0] cmp_val,
  input  logic [W-1:0] top_val,
  input  logic [1:0]   out_mode,
  input  logic [1:0]   wave_fam,
  input  logic         ext_mode,
  input  logic         dir_en,
  output logic         pin_out,
  output logic         pin_own
);

  evt_t evt;
  act_e act;
  logic linked;
  logic wave_q;
  logic wave_d;
  logic own_d;

  ocg_event #(.W(W)) u_evt (
    .cnt_step (cnt_step),
    .cnt_val  (cnt_val),
    .cmp_val  (cmp_val),
    .top_val  (top_val),
    .evt      (evt)
  );

  ocg_decode u_dec (
    .wave_fam (wave_fam),
    .out_mode (out_mode),
    .ext_mode (ext_mode),
    .cnt_down (cnt_down),
    .evt      (evt),
    .act      (act),
    .linked   (linked)
  );

  always_comb begin
    unique case (act)
      ACT_CLR: wave_d = 1'b0;
      ACT_SET: wave_d = 1'b1;
      ACT_TOG: wave_d = ~wave_q;
      default: wave_d = wave_q;
    endcase
    own_d = linked && dir_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wave_q  <= 1'b0;
      pin_out <= 1'b0;
      pin_own <= 1'b0;
    end else begin
      wave_q  <= wave_d;
      pin_out <= own_d && wave_d;
      pin_own <= own_d;
    end
  end

endmodule

// File: rtl/ocg_wavegen_chk.sv
module ocg_wavegen_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         cnt_step,
  input logic [W-1:0] cnt_val,
  input logic [W-1:0] cmp_val,
  input logic [W-1:0] top_val,
  input logic [1:0]   out_mode,
  input logic [1:0]   wave_fam,
  input logic         ext_mode,
  input logic         dir_en,
  input logic         wave_q,
  input logic         pin_out,
  input logic         pin_own
);

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> !pin_own && !pin_out && !wave_q);

  p_plain_set_r2: assert property (@(posedge clk) disable iff (rst)
    (wave_fam == 2'd0 && out_mode == 2'd3 && cnt_step && cnt_val == cmp_val) |=> wave_q);

  p_plain_tog_r2: assert property (@(posedge clk) disable iff (rst)
    (wave_fam == 2'd0 && out_mode == 2'd1 && cnt_step && cnt_val == cmp_val)
    |=> wave_q != $past(wave_q));

  p_fast_top_r3: assert property (@(posedge clk) disable iff (rst)
    (wave_fam == 2'd1 && out_mode == 2'd2 && cnt_step && cnt_val == top_val) |=> wave_q);

  p_pwm_detach_r5: assert property (@(posedge clk) disable iff (rst)
    ((wave_fam == 2'd1 || wave_fam == 2'd2) && out_mode == 2'd1 && !ext_mode)
    |=> $stable(wave_q) && !pin_own);

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !cnt_step |=> $stable(wave_q));

  p_dir_gate_r8: assert property (@(posedge clk) disable iff (rst)
    (!dir_en || out_mode == 2'd0) |=> !pin_own && !pin_out);

  p_pin_level_r8: assert property (@(posedge clk) disable iff (rst)
    pin_own |-> pin_out == wave_q);

endmodule

bind ocg_wavegen ocg_wavegen_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cnt_step (cnt_step),
  .cnt_val  (cnt_val),
  .cmp_val  (cmp_val),
  .top_val  (top_val),
  .out_mode (out_mode),
  .wave_fam (wave_fam),
  .ext_mode (ext_mode),
  .dir_en   (dir_en),
  .wave_q   (wave_q),
  .pin_out  (pin_out),
  .pin_own  (pin_own)
);

// File: tb/sim_ocg_wavegen.sv
`timescale 1ns/1ps
module sim_ocg_wavegen;

  localparam int W    = 8;
  localparam int TOPV = 7;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cnt_step = 1'b0;
  logic [W-1:0] cnt_val = '0;
  logic         cnt_down = 1'b0;
  logic [W-1:0] cmp_val = '0;
  logic [W-1:0] top_val = W'(TOPV);
  logic [1:0]   out_mode = 2'd0;
  logic [1:0]   wave_fam = 2'd0;
  logic         ext_mode = 1'b0;
  logic         dir_en = 1'b0;
  logic         pin_out;
  logic         pin_own;

  int  n_vec  = 0;
  int  n_bad  = 0;
  logic exp_wave = 1'b0;

  always #2.5 clk = ~clk;

  ocg_wavegen #(.W(W)) u0 (
    .clk(clk), .rst(rst), .cnt_step(cnt_step), .cnt_val(cnt_val),
    .cnt_down(cnt_down), .cmp_val(cmp_val), .top_val(top_val),
    .out_mode(out_mode), .wave_fam(wave_fam), .ext_mode(ext_mode),
    .dir_en(dir_en), .pin_out(pin_out), .pin_own(pin_own)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b (fam %0d mode %0d ext %0d cnt %0d cmp %0d)",
               tag, what, act, exp, wave_fam, out_mode, ext_mode, cnt_val, cmp_val);
    end
  endtask

  function automatic logic is_pwm(input logic [1:0] f);
    return (f == 2'd1) || (f == 2'd2);
  endfunction

  function automatic logic connected(input logic [1:0] f, input logic [1:0] m, input logic e);
    return (m != 2'd0) && !(is_pwm(f) && m == 2'd1 && !e);
  endfunction

  // next waveform level predicted from the requirement text
  function automatic logic predict(input logic [1:0] f, input logic [1:0] m, input logic e,
                                   input logic d, input logic s, input int c, input int cp,
                                   input int tp, input logic cur);
    logic match, top;
    match = (c == cp);
    top   = (c == tp);
    if (!s || !connected(f, m, e)) return cur;
    if (!is_pwm(f)) begin
      if (!match) return cur;
      case (m)
        2'd1:    return ~cur;
        2'd2:    return 1'b0;
        default: return 1'b1;
      endcase
    end
    if (m == 2'd1) return match ? ~cur : cur;
    if (cp == tp) return top ? (m == 2'd2) : cur;
    if (f == 2'd1) begin
      if (top)   return (m == 2'd2);
      if (match) return (m == 2'd3);
      return cur;
    end
    if (!match) return cur;
    return d ? (m == 2'd2) : (m == 2'd3);
  endfunction

  function automatic string auto_tag(input logic [1:0] f, input logic [1:0] m, input int cp);
    if (!is_pwm(f)) return "R2";
    if (m == 2'd1) return "R5";
    if (m[1] && cp == TOPV) return "R6";
    if (f == 2'd1) return "R3";
    return "R4";
  endfunction

  // one clocked cycle with the given strobe/count, then compare outputs
  task automatic cycle(input string tag, input logic s, input int c, input logic d, input logic de);
    logic nw, own;
    cnt_step = s;
    cnt_val  = W'(c);
    cnt_down = d;
    dir_en   = de;
    nw  = predict(wave_fam, out_mode, ext_mode, d, s, c, int'(cmp_val), int'(top_val), exp_wave);
    own = connected(wave_fam, out_mode, ext_mode) && de;
    @(posedge clk);
    #1;
    check(tag, "pin_out", pin_out, own && nw);
    check("R8", "pin_own", pin_own, own);
    exp_wave = nw;
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // R1: reset must win over a live set-on-match request
    wave_fam = 2'd0; out_mode = 2'd3; cmp_val = 8'd2; cnt_val = 8'd2;
    cnt_step = 1'b1; dir_en = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "pin_out", pin_out, 1'b0);
    check("R1", "pin_own", pin_own, 1'b0);
    rst = 1'b0; cnt_step = 1'b0; out_mode = 2'd0;
    @(posedge clk); #1;
    check("R1", "pin_own idle", pin_own, 1'b0);

    for (int f = 0; f < 4; f++) begin
      for (int m = 0; m < 4; m++) begin
        for (int e = 0; e < 2; e++) begin
          for (int ci = 0; ci < 3; ci++) begin
            int cp, len, n;
            cp = (ci == 0) ? 0 : (ci == 1) ? 3 : TOPV;
            wave_fam = 2'(f); out_mode = 2'(m); ext_mode = 1'(e); cmp_val = W'(cp);
            len = (f == 2) ? 4 * TOPV : 2 * (TOPV + 1);
            n = 0;
            for (int k = 0; k < len; k++) begin
              int c; logic d;
              if (f == 2) begin
                int p;
                p = k % (2 * TOPV);
                c = (p <= TOPV) ? p : 2 * TOPV - p;
                d = (p > TOPV);
              end else begin
                c = k % (TOPV + 1);
                d = 1'b0;
              end
              cycle(auto_tag(2'(f), 2'(m), cp), 1'b1, c, d, (n % 6) != 5);
              // R7: stalled cycle parked on the compare value
              cycle("R7", 1'b0, cp, d, 1'b1);
              n++;
            end
          end
        end
      end
    end

    // R9: set the level, detach, strobe matches, reattach with no event
    wave_fam = 2'd0; ext_mode = 1'b0; cmp_val = 8'd2;
    out_mode = 2'd2; cycle("R2", 1'b1, 2, 1'b0, 1'b1);
    out_mode = 2'd3; cycle("R2", 1'b1, 2, 1'b0, 1'b1);
    out_mode = 2'd0;
    cycle("R9", 1'b1, 2, 1'b0, 1'b1);
    cycle("R9", 1'b1, 2, 1'b0, 1'b1);
    out_mode = 2'd2; cycle("R9", 1'b1, 5, 1'b0, 1'b1);
    check("R9", "retained level", pin_out, 1'b1);
    // R5: PWM toggle mode with extra bit clear detaches and freezes
    wave_fam = 2'd1; out_mode = 2'd1; ext_mode = 1'b0;
    cycle("R5", 1'b1, 2, 1'b0, 1'b1);
    wave_fam = 2'd0; out_mode = 2'd3; cmp_val = 8'd6;
    cycle("R9", 1'b1, 1, 1'b0, 1'b1);
    check("R9", "level after detach", pin_out, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule